// File: doc/BRIEF.md
# Cache-Line Burst Bus Engine

This block moves data between a cache and a 64-bit external data bus. Requests come from the cache side through a valid/ready handshake. Each request asks for one of two kinds of bus cycle:

- A single cycle moves one 64-bit word. Byte enables pick which bytes of that word take part.
- A burst cycle moves one full 32-byte cache line as four consecutive 64-bit beats. A burst read fills a line. A burst write copies a dirty line back to memory.

The cache always uses bursts for its own traffic. Uncached accesses use the single-beat path.

On the bus side, the engine keeps a cycle open while it waits for the external ready signal. Each beat completes on a clock edge where ready is high, so the slave may insert any number of wait states. After the final beat of a transfer, the engine gives the requester a one-cycle completion pulse. For reads, the assembled line, or the single word, is presented on the result ports in that same cycle. The engine serves one request at a time and holds off new requests until the current transfer has finished.

Top module: `line_burst_bif`

## Requirements
- R1: Reset state. While reset is held and right after it is released, `req_ready` is 1 and both `bus_valid` and `done` are 0.
- R2: Request acceptance.
  - A request is accepted only on a clock edge where both `req_valid` and `req_ready` are high.
  - `bus_valid` rises in the cycle after acceptance.
  - `req_ready` stays low from then until the cycle after `done`.
  - Requests presented during that time have no effect and start no later transfer.
- R3: Burst addressing.
  - A burst is a `req_kind` with bit 1 set.
  - A burst performs exactly four beats.
  - Each beat's address is the request address with its low 5 bits cleared, plus 8 times the beat index (0, 1, 2, 3 in that order).
  - During a burst, `bus_burst` is 1 and all eight bits of `bus_be` are 1.
- R4: Burst read data. On a burst read (`req_kind` = 2'b10), the data taken on beat i lands in `rd_line[64*i+63:64*i]`. The whole line is valid in the cycle `done` is high.
- R5: Burst write data. On a burst write (`req_kind` = 2'b11), beat i drives `req_wline[64*i+63:64*i]` on `bus_wdata` and holds `bus_we` at 1. Reads hold `bus_we` at 0.
- R6: Wait states.
  - A beat completes only on an edge where `bus_ready` is high.
  - While `bus_ready` is low, `bus_addr`, `bus_be` and `bus_wdata` hold their values.
  - Read data is not captured while `bus_ready` is low.
- R7: Single transfers.
  - A single transfer is a `req_kind` with bit 1 clear (2'b00 read, 2'b01 write). It performs exactly one beat.
  - During that beat, `bus_burst` is 0 and the address is the request address with its low 3 bits cleared.
  - `bus_be` equals `req_be`, and for writes `bus_wdata` equals `req_wdata`.
  - A single read returns the beat's data on `rd_data` in the cycle `done` is high.
- R8: Completion. `done` is a one-cycle pulse in the cycle right after the edge that completes the final beat. It is never high twice in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester presents a transfer |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_kind | input | 2 | Bit 1 selects burst, bit 0 selects write |
| req_addr | input | 32 | Byte address of the request |
| req_wline | input | 256 | Line to write back on a burst write |
| req_wdata | input | 64 | Word for a single write |
| req_be | input | 8 | Byte enables for a single transfer |
| done | output | 1 | One-cycle completion pulse |
| rd_line | output | 256 | Assembled line of a burst read, valid with done |
| rd_data | output | 64 | Word of a single read, valid with done |
| bus_valid | output | 1 | Bus cycle in progress, current beat presented |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_we | output | 1 | Current cycle is a write |
| bus_burst | output | 1 | Current cycle is a line burst |
| bus_be | output | 8 | Byte enables of the current beat |
| bus_wdata | output | 64 | Write data of the current beat |
| bus_rdata | input | 64 | Read data from the bus |
| bus_ready | input | 1 | Slave completes the current beat on this edge |

## Verification
The assertions assume a slave whose `bus_ready` matters only while `bus_valid` is high. They also assume a requester that may raise `req_valid` at any time, including while a transfer is open. The stimulus drives `bus_ready` at random, with per-transfer probabilities from 20 to 100 percent, so both back-to-back beats and long wait runs occur. Random `bus_rdata` is presented during wait cycles, so capturing data without ready would show up in the returned line. Stray requests with random kind and address are injected while the engine is busy. They must leave no trace once the engine returns to idle.

// File: rtl/lbb_pkg.sv
`timescale 1ns/1ps
package lbb_pkg;

    // bit 1 = burst, bit 0 = write
    typedef enum logic [1:0] {
        K_SRD = 2'b00,
        K_SWR = 2'b01,
        K_BRD = 2'b10,
        K_BWR = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } eng_state_e;

    function automatic logic kind_is_burst(input xfer_kind_e k);
        return (k == K_BRD) || (k == K_BWR);
    endfunction

    function automatic logic kind_is_write(input xfer_kind_e k);
        return (k == K_SWR) || (k == K_BWR);
    endfunction

endpackage

// File: rtl/lbb_beat_seq.sv
`timescale 1ns/1ps
// Beat index counter: cleared on start, stepped on each completed beat.
module lbb_beat_seq #(
    parameter int BEATS = 4,
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          adv,
    input  logic          burst,
    output logic [BW-1:0] beat,
    output logic          last
);
    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign beat = cnt_q;
    assign last = !burst || (cnt_q == BW'(BEATS - 1));
endmodule

// File: rtl/lbb_line_store.sv
`timescale 1ns/1ps
// One line register shared by write-back source and read assembly.
module lbb_line_store #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int LINE_W = DATA_W * BEATS,
    localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] load_line,
    input  logic              cap,
    input  logic [BW-1:0]     sel,
    input  logic [DATA_W-1:0] cap_data,
    output logic [DATA_W-1:0] beat_out,
    output logic [LINE_W-1:0] line_out
);
    logic [DATA_W-1:0] slot_q [BEATS];

    for (genvar i = 0; i < BEATS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (load) begin
                slot_q[i] <= load_line[i*DATA_W +: DATA_W];
            end else if (cap && (sel == BW'(i))) begin
                slot_q[i] <= cap_data;
            end
        end
        assign line_out[i*DATA_W +: DATA_W] = slot_q[i];
    end

    assign beat_out = slot_q[sel];
endmodule

// File: rtl/line_burst_bif.sv
`timescale 1ns/1ps
module line_burst_bif
    import lbb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int LINE_W = DATA_W * BEATS,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wline,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              done,
    output logic [LINE_W-1:0] rd_line,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_burst,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BEAT_SH = $clog2(BE_W);
    localparam int LINE_SH = $clog2(BE_W * BEATS);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((64'd1 << LINE_SH) - 1);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((64'd1 << BEAT_SH) - 1);

    eng_state_e        state_q;
    xfer_kind_e        kind_q;
    xfer_kind_e        kind_in;
    logic [ADDR_W-1:0] base_q;
    logic [BE_W-1:0]   be_q;
    logic              accept;
    logic              beat_adv;
    logic              in_burst;
    logic [BW-1:0]     beat;
    logic              last;
    logic [DATA_W-1:0] beat_wdata;
    logic [LINE_W-1:0] load_line;

    assign kind_in  = xfer_kind_e'(req_kind);
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign beat_adv = (state_q == ST_XFER) && bus_ready;
    assign in_burst = kind_is_burst(kind_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= K_SRD;
            base_q  <= '0;
            be_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_XFER;
                        kind_q  <= kind_in;
                        base_q  <= req_addr & (kind_is_burst(kind_in) ? LINE_MASK : WORD_MASK);
                        be_q    <= req_be;
                    end
                end
                ST_XFER: begin
                    if (beat_adv && last) begin
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    lbb_beat_seq #(.BEATS(BEATS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .adv   (beat_adv),
        .burst (in_burst),
        .beat  (beat),
        .last  (last)
    );

    assign load_line = kind_is_burst(kind_in) ? req_wline : LINE_W'(req_wdata);

    lbb_line_store #(.DATA_W(DATA_W), .BEATS(BEATS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_line (load_line),
        .cap       (beat_adv && !kind_is_write(kind_q)),
        .sel       (beat),
        .cap_data  (bus_rdata),
        .beat_out  (beat_wdata),
        .line_out  (rd_line)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign rd_data   = rd_line[DATA_W-1:0];
    assign bus_valid = (state_q == ST_XFER);
    assign bus_we    = kind_is_write(kind_q);
    assign bus_burst = in_burst;
    assign bus_addr  = base_q | (ADDR_W'(beat) << BEAT_SH);
    assign bus_be    = in_burst ? {BE_W{1'b1}} : be_q;
    assign bus_wdata = (bus_valid && bus_we) ? beat_wdata : '0;
endmodule

// File: rtl/lbb_checker.sv
`timescale 1ns/1ps
module lbb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    localparam int BE_W    = DATA_W / 8,
    localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int BEAT_SH = $clog2(BE_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_burst,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready
);
    logic [BW:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || done) begin
            seen_q <= '0;
        end else if (bus_valid && bus_ready) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !req_ready);
    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> bus_valid);
    assert_beat_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_burst) |-> (bus_addr[BEAT_SH +: BW] == seen_q[BW-1:0]));
    assert_full_be_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_burst) |-> (&bus_be));
    assert_word_align_R7: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_addr[BEAT_SH-1:0] == '0));
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_be) && $stable(bus_wdata)));
    assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_valid && bus_ready));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_beat_count_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen_q == (bus_burst ? (BW+1)'(BEATS) : (BW+1)'(1))));
endmodule

bind line_burst_bif lbb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BEATS  (BEATS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_burst (bus_burst),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/line_burst_bif_bench.sv
`timescale 1ns/1ps
module line_burst_bif_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [1:0]   req_kind;
    logic [31:0]  req_addr;
    logic [255:0] req_wline;
    logic [63:0]  req_wdata;
    logic [7:0]   req_be;
    logic         done;
    logic [255:0] rd_line;
    logic [63:0]  rd_data;
    logic         bus_valid;
    logic [31:0]  bus_addr;
    logic         bus_we;
    logic         bus_burst;
    logic [7:0]   bus_be;
    logic [63:0]  bus_wdata;
    logic [63:0]  bus_rdata;
    logic         bus_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    line_burst_bif u_line_burst_bif (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_wline(req_wline),
        .req_wdata(req_wdata), .req_be(req_be), .done(done), .rd_line(rd_line),
        .rd_data(rd_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_burst(bus_burst), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a ^ 32'h5EED_0000, a};
    endfunction

    function automatic logic [255:0] rnd_line();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic run_xfer(input logic [1:0] kind, input logic [31:0] addr,
                            input logic [255:0] wl, input logic [63:0] ws,
                            input logic [7:0] be, input int ready_pct);
        bit           burst = kind[1];
        bit           wr    = kind[0];
        int           nb    = burst ? 4 : 1;
        logic [31:0]  base  = burst ? (addr & ~32'h1F) : (addr & ~32'h7);
        logic [255:0] exp_line = '0;
        int           beat = 0;
        logic [31:0]  ea;
        bit           rdy;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle ready", 256'(req_ready), 256'd1);
        req_valid = 1'b1; req_kind = kind; req_addr = addr;
        req_wline = wl; req_wdata = ws; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        while (beat < nb) begin
            ea = base + 32'(beat * 8);
            chk(bus_valid == 1'b1, "R2 bus_valid", 256'(bus_valid), 256'd1);
            chk(req_ready == 1'b0, "R2 busy", 256'(req_ready), 256'd0);
            chk(bus_addr == ea, burst ? "R3 addr" : "R7 addr", 256'(bus_addr), 256'(ea));
            chk(bus_burst == burst, "R3 burst flag", 256'(bus_burst), 256'(burst));
            chk(bus_we == wr, "R5 we", 256'(bus_we), 256'(wr));
            chk(bus_be == (burst ? 8'hFF : be), burst ? "R3 be" : "R7 be",
                256'(bus_be), 256'(burst ? 8'hFF : be));
            if (wr) begin
                logic [63:0] ew = burst ? wl[beat*64 +: 64] : ws;
                chk(bus_wdata == ew, burst ? "R5 wdata" : "R7 wdata",
                    256'(bus_wdata), 256'(ew));
            end
            rdy = ($urandom % 100) < ready_pct;
            bus_ready = rdy;
            bus_rdata = rdy ? mem_word(ea) : {$urandom, $urandom};
            if (rdy) exp_line[beat*64 +: 64] = mem_word(ea);
            if (($urandom % 4) == 0) begin
                req_valid = 1'b1; req_kind = 2'($urandom); req_addr = $urandom;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            if (rdy) beat++;
        end
        bus_ready = 1'b0;
        req_valid = 1'b0;
        chk(done == 1'b1, "R8 done", 256'(done), 256'd1);
        if (!wr && burst)
            chk(rd_line == exp_line, "R4 rd_line", rd_line, exp_line);
        if (!wr && !burst)
            chk(rd_data == exp_line[63:0], "R7 rd_data", 256'(rd_data), 256'(exp_line[63:0]));
        @(negedge clk);
        chk(done == 1'b0, "R8 pulse", 256'(done), 256'd0);
        chk(bus_valid == 1'b0, "R2 stray ignored", 256'(bus_valid), 256'd0);
        chk(req_ready == 1'b1, "R2 ready again", 256'(req_ready), 256'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
        req_wline = '0; req_wdata = '0; req_be = '0; bus_rdata = '0; bus_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R1 in reset",
            256'({req_ready, bus_valid, done}), 256'(3'b100));
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_valid == 1'b0 && done == 1'b0, "R1 after reset",
            256'({req_ready, bus_valid, done}), 256'(3'b100));

        // directed corners
        run_xfer(2'b10, 32'h0000_1000, '0, '0, 8'h00, 100);          // aligned fill, no waits
        run_xfer(2'b10, 32'h0000_2037, '0, '0, 8'h00, 30);           // unaligned fill, many waits (R6)
        run_xfer(2'b11, 32'hFFFF_FFE8, rnd_line(), '0, 8'h00, 100);  // write-back at top of space
        run_xfer(2'b11, 32'h0000_0040, rnd_line(), '0, 8'h00, 25);   // write-back with waits (R6)
        run_xfer(2'b01, 32'h0000_0105, '0, 64'h1122_3344_5566_7788, 8'h01, 100);
        run_xfer(2'b00, 32'h0000_0ABF, '0, '0, 8'hF0, 40);

        for (int n = 0; n < 60; n++) begin
            run_xfer(2'($urandom), $urandom, rnd_line(), {$urandom, $urandom},
                     8'($urandom), 20 + int'($urandom % 81));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule